// File: doc/BRIEF.md
# Prioritized Memory Select Decoder

This block turns the address bus and the access strobes of an 8-bit microcontroller into chip selects for three regions: SRAM with its I/O space, a secondary (boot) flash, and the main flash. The processor keeps code and data in separate spaces. A code fetch is qualified by a program-fetch strobe, and a data access by a read or write strobe. Each memory can be placed in code space, in data space or in both. That placement is held in an 8-bit space-mapping register.

Region boundaries are parameters, and the regions may overlap. When more than one memory is a legal candidate for an access, a fixed priority picks the winner: SRAM/I/O first, then boot flash, then main flash. The mapping register sits in a small control window. Software can rewrite it at any time, for example to swap the two flashes between code and data space. The selects are combinational from the address and strobes. A register write takes effect from the cycle after the write edge.

Top module: `memsel_decoder`

## Requirements
- R1: On a clock edge with `rst_n` low, the mapping register loads the parameter `CFG_RESET` with bits 6 and 5 forced to 0 (default 8'hE9 gives 8'h89). The register reads back on `ctl_rdata` when `ctl_sel` is high and `addr[7:0]` equals `CFG_OFS` (default 8'hC2); otherwise `ctl_rdata` is 0.
- R2: The register is written from `ctl_wdata` on a clock edge only when `ctl_sel`, `ctl_wr` and an `addr[7:0]` match to `CFG_OFS` are all present. Bits 6 and 5 always read as 0. Any other combination leaves the register unchanged.
- R3: On a code fetch (`code_fetch` high), a region inside its address range is a candidate only if its code bit is set: bit 0 for SRAM, bit 1 for boot flash, bit 2 for main flash.
- R4: On a data access (`data_rd` or `data_wr` high), SRAM inside its range is always a candidate. Boot flash is a candidate when bit 3 is set and main flash when bit 4 is set.
- R5: Among the candidates, SRAM wins over boot flash and boot flash wins over main flash. A disabled higher-priority region lets a lower one through. At most one select is high.
- R6: With no access strobe high, or with `ctl_sel` high, no memory select is asserted.
- R7: When `pio_mode` is high and bit 7 is 0, neither flash is selected. With bit 7 set, or with `pio_mode` low, the flash selects follow R3 to R5.
- R8: A new mapping applies to accesses in the cycle right after the write edge, so the two flashes can be swapped between consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Address bus; the low 8 bits also index the control window |
| code_fetch | input | 1 | Program fetch strobe, active high |
| data_rd | input | 1 | Data read strobe, active high |
| data_wr | input | 1 | Data write strobe, active high |
| pio_mode | input | 1 | Ports run in parallel I/O mode |
| ctl_sel | input | 1 | Control window select |
| ctl_wr | input | 1 | Control window write enable |
| ctl_wdata | input | 8 | Control window write data |
| ctl_rdata | output | 8 | Control window read data |
| sel_sram | output | 1 | SRAM / I/O select |
| sel_boot | output | 1 | Boot flash select |
| sel_main | output | 1 | Main flash select |

## Verification
Remapping and priority selection can fall in the same cycle: a register write can be followed at once by an access to an overlap address, so one edge changes which region wins. The bench provokes this with directed swaps of the two flashes. It also drives random streams in which control-window writes with random data are mixed with fetches and data accesses. Each select is compared against a bench model whose register copy is updated only at the write edge, so a mapping applied a cycle early or late shows up as a wrong winner.

// File: rtl/memsel_pkg.sv
// Shared constants for the memory select decoder.
// Assumes an 8-bit mapping register and three regions indexed in priority order.
package memsel_pkg;
    localparam int CFG_W        = 8;
    localparam int NREG         = 3;
    // region index doubles as priority (lower index wins)
    localparam int RG_SRAM      = 0;
    localparam int RG_BOOT      = 1;
    localparam int RG_MAIN      = 2;
    // mapping register bit positions
    localparam int B_SRAM_CODE  = 0;
    localparam int B_BOOT_CODE  = 1;
    localparam int B_MAIN_CODE  = 2;
    localparam int B_BOOT_DATA  = 3;
    localparam int B_MAIN_DATA  = 4;
    localparam int B_PIO_FLASH  = 7;
    localparam logic [CFG_W-1:0] CFG_KEEP = 8'h9F;

    typedef struct packed {
        logic code_en;
        logic data_en;
    } space_en_t;
endpackage

// File: rtl/memsel_cfg_reg.sv
// Space-mapping register in the control window.
// Assumes the window offset is compared on the low address bits and the reset is synchronous.
module memsel_cfg_reg
    import memsel_pkg::*;
#(
    parameter int               OFS_W     = 8,
    parameter logic [OFS_W-1:0] CFG_OFS   = 8'hC2,
    parameter logic [CFG_W-1:0] CFG_RESET = 8'hE9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_sel,
    input  logic             win_wr,
    input  logic [OFS_W-1:0] win_ofs,
    input  logic [CFG_W-1:0] win_wdata,
    output logic [CFG_W-1:0] cfg,
    output logic [CFG_W-1:0] rdata
);
    localparam logic [CFG_W-1:0] RESET_VAL = CFG_RESET & CFG_KEEP;

    logic hit;
    logic wr_en;

    // offset decode of the window access
    always_comb begin
        hit   = win_sel && (win_ofs == CFG_OFS);
        wr_en = hit && win_wr;
    end

    // register update: reset value, or masked write data
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= RESET_VAL;
        else if (wr_en)
            cfg <= win_wdata & CFG_KEEP;
    end

    // readback mux, zero when the window does not address the register
    always_comb begin
        rdata = hit ? cfg : '0;
    end

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg[6:5] == 2'b00);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (win_sel && win_wr && win_ofs == CFG_OFS) |=> cfg == ($past(win_wdata) & CFG_KEEP));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_sel && win_wr && win_ofs == CFG_OFS) |=> $stable(cfg));
endmodule

// File: rtl/memsel_range_match.sv
// Inclusive address range comparator for one region.
// Assumes LO <= HI; the result is purely combinational.
module memsel_range_match #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] LO     = '0,
    parameter logic [ADDR_W-1:0] HI     = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // bounds compare
    always_comb begin
        hit = (addr >= LO) && (addr <= HI);
    end
endmodule

// File: rtl/memsel_priority.sv
// Fixed-priority picker: the lowest-index request wins.
// Assumes request bit 0 has the highest priority.
module memsel_priority #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // scan from the highest priority and stop at the first request
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/memsel_decoder.sv
// Memory select decoder: range hit, space qualification, flash PIO gate, fixed priority.
// Assumes active-high strobes and that the control window is exclusive of memory accesses.
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                OFS_W     = 8,
    parameter logic [OFS_W-1:0]  CFG_OFS   = 8'hC2,
    parameter logic [7:0]        CFG_RESET = 8'hE9,
    parameter logic [ADDR_W-1:0] SRAM_LO   = 16'h8000,
    parameter logic [ADDR_W-1:0] SRAM_HI   = 16'h87FF,
    parameter logic [ADDR_W-1:0] BOOT_LO   = 16'h6000,
    parameter logic [ADDR_W-1:0] BOOT_HI   = 16'h9FFF,
    parameter logic [ADDR_W-1:0] MAIN_LO   = 16'h0000,
    parameter logic [ADDR_W-1:0] MAIN_HI   = 16'h7FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              code_fetch,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              pio_mode,
    input  logic              ctl_sel,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    output logic              sel_sram,
    output logic              sel_boot,
    output logic              sel_main
);
    localparam logic [NREG*ADDR_W-1:0] LO_VEC = {MAIN_LO, BOOT_LO, SRAM_LO};
    localparam logic [NREG*ADDR_W-1:0] HI_VEC = {MAIN_HI, BOOT_HI, SRAM_HI};

    logic [CFG_W-1:0] cfg;
    logic [NREG-1:0]  hit;
    logic [NREG-1:0]  cand;
    logic [NREG-1:0]  gnt;
    space_en_t        sp [NREG];
    logic             data_acc;
    logic             flash_ok;

    memsel_cfg_reg #(
        .OFS_W     (OFS_W),
        .CFG_OFS   (CFG_OFS),
        .CFG_RESET (CFG_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_sel   (ctl_sel),
        .win_wr    (ctl_wr),
        .win_ofs   (addr[OFS_W-1:0]),
        .win_wdata (ctl_wdata),
        .cfg       (cfg),
        .rdata     (ctl_rdata)
    );

    // one range comparator per region
    for (genvar g = 0; g < NREG; g++) begin : g_rng
        memsel_range_match #(
            .ADDR_W (ADDR_W),
            .LO     (LO_VEC[g*ADDR_W +: ADDR_W]),
            .HI     (HI_VEC[g*ADDR_W +: ADDR_W])
        ) u_rng (
            .addr (addr),
            .hit  (hit[g])
        );
    end

    // per-region space enables taken from the mapping register
    always_comb begin
        sp[RG_SRAM] = '{code_en: cfg[B_SRAM_CODE], data_en: 1'b1};
        sp[RG_BOOT] = '{code_en: cfg[B_BOOT_CODE], data_en: cfg[B_BOOT_DATA]};
        sp[RG_MAIN] = '{code_en: cfg[B_MAIN_CODE], data_en: cfg[B_MAIN_DATA]};
    end

    // access class and flash gate for PIO mode
    always_comb begin
        data_acc = data_rd || data_wr;
        flash_ok = !pio_mode || cfg[B_PIO_FLASH];
    end

    // candidate set: in range, enabled for the access space, not blocked
    for (genvar g = 0; g < NREG; g++) begin : g_cand
        logic gate;
        assign gate = (g == RG_SRAM) ? 1'b1 : flash_ok;
        always_comb begin
            cand[g] = hit[g] && !ctl_sel && gate &&
                      ((code_fetch && sp[g].code_en) || (data_acc && sp[g].data_en));
        end
    end

    memsel_priority #(.N(NREG)) u_pri (
        .req (cand),
        .gnt (gnt)
    );

    // output naming
    always_comb begin
        sel_sram = gnt[RG_SRAM];
        sel_boot = gnt[RG_BOOT];
        sel_main = gnt[RG_MAIN];
    end

    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_main, sel_boot, sel_sram}));
    a_r6_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_fetch || data_rd || data_wr) |-> !(sel_sram || sel_boot || sel_main));
    a_r6_window: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_sel |-> !(sel_sram || sel_boot || sel_main));
    a_r7_pio_block: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_mode && !cfg[B_PIO_FLASH]) |-> !(sel_boot || sel_main));
    a_r5_sram_first: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ctl_sel && addr >= SRAM_LO && addr <= SRAM_HI) |-> sel_sram);
endmodule

// File: tb/memsel_decoder_tb.sv
module memsel_decoder_tb;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] OFS        = 8'hC2;
    localparam logic [7:0] KEEP       = 8'h9F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        code_fetch = 0, data_rd = 0, data_wr = 0, pio_mode = 0;
    logic        ctl_sel = 0, ctl_wr = 0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        sel_sram, sel_boot, sel_main;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model_cfg = 8'h89;

    always #(CLK_PERIOD/2) clk = ~clk;

    memsel_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .code_fetch(code_fetch),
        .data_rd(data_rd), .data_wr(data_wr), .pio_mode(pio_mode),
        .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sel_sram(sel_sram), .sel_boot(sel_boot),
        .sel_main(sel_main)
    );

    // expected {main, boot, sram} from the requirements
    function automatic logic [2:0] exp_sel(input logic [15:0] a, input logic cf, rd, wr,
                                           input logic pio, cs, input logic [7:0] c);
        logic hs, hb, hm, dacc, fok, cs_s, cs_b, cs_m;
        hs = a >= 16'h8000 && a <= 16'h87FF;
        hb = a >= 16'h6000 && a <= 16'h9FFF;
        hm = a <= 16'h7FFF;
        dacc = rd || wr;
        fok = !pio || c[7];
        cs_s = !cs && hs && ((cf && c[0]) || dacc);
        cs_b = !cs && fok && hb && ((cf && c[1]) || (dacc && c[3]));
        cs_m = !cs && fok && hm && ((cf && c[2]) || (dacc && c[4]));
        if (cs_s) return 3'b001;
        if (cs_b) return 3'b010;
        if (cs_m) return 3'b100;
        return 3'b000;
    endfunction

    task automatic step(input string req, input logic [15:0] a, input logic cf, rd, wr,
                        input logic pio, cs, cw, input logic [7:0] wd);
        logic [2:0] e;
        logic [7:0] er;
        @(negedge clk);
        addr = a; code_fetch = cf; data_rd = rd; data_wr = wr; pio_mode = pio;
        ctl_sel = cs; ctl_wr = cw; ctl_wdata = wd;
        #1;
        e  = exp_sel(a, cf, rd, wr, pio, cs, model_cfg);
        er = (cs && a[7:0] == OFS) ? model_cfg : 8'h00;
        n_chk++;
        if ({sel_main, sel_boot, sel_sram} !== e) begin
            n_err++;
            $display("FAIL %s sel addr=%h act=%b exp=%b", req, a, {sel_main, sel_boot, sel_sram}, e);
        end
        n_chk++;
        if (ctl_rdata !== er) begin
            n_err++;
            $display("FAIL %s rdata act=%h exp=%h", req, ctl_rdata, er);
        end
        @(posedge clk);
        if (cs && cw && a[7:0] == OFS) model_cfg = wd & KEEP;
    endtask

    task automatic wr_cfg(input string req, input logic [7:0] d);
        step(req, {8'h00, OFS}, 0, 0, 0, 0, 1, 1, d);
    endtask

    task automatic rd_cfg(input string req);
        step(req, {8'h00, OFS}, 0, 0, 0, 0, 1, 0, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset value with bits 6:5 masked
        rd_cfg("R1");
        // R3 code fetch into SRAM, R4 data read into boot flash
        step("R3", 16'h8100, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 16'h7000, 0, 1, 0, 0, 0, 0, 0);
        // R2 write with unused bits set, then ignored writes
        wr_cfg("R2", 8'hFF);
        rd_cfg("R2");
        step("R2", 16'h00C3, 0, 0, 0, 0, 1, 1, 8'h00);
        step("R2", {8'h00, OFS}, 0, 0, 0, 0, 1, 0, 8'h00);
        rd_cfg("R2");
        // R5 overlaps with everything enabled
        step("R5", 16'h7000, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 16'h8100, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 16'h9000, 0, 1, 0, 0, 0, 0, 0);
        step("R5", 16'h1000, 1, 0, 0, 0, 0, 0, 0);
        // R6 no strobe, and window access
        step("R6", 16'h8100, 0, 0, 0, 0, 0, 0, 0);
        step("R6", 16'h8100, 0, 1, 0, 0, 1, 0, 0);
        // R5 fall-through and R4 SRAM always in data space
        wr_cfg("R5", 8'h05);
        step("R5", 16'h7000, 1, 0, 0, 0, 0, 0, 0);
        step("R4", 16'h8100, 0, 1, 0, 0, 0, 0, 0);
        step("R4", 16'h7000, 0, 1, 0, 0, 0, 0, 0);
        step("R4", 16'h8100, 0, 0, 1, 0, 0, 0, 0);
        // R7 PIO gate
        step("R7", 16'h1000, 1, 0, 0, 1, 0, 0, 0);
        step("R7", 16'h8100, 1, 0, 0, 1, 0, 0, 0);
        wr_cfg("R7", 8'h85);
        step("R7", 16'h1000, 1, 0, 0, 1, 0, 0, 0);
        // R8 swap flashes on consecutive cycles
        wr_cfg("R8", 8'h14);
        step("R8", 16'h7000, 1, 0, 0, 0, 0, 0, 0);
        wr_cfg("R8", 8'h0A);
        step("R8", 16'h7000, 1, 0, 0, 0, 0, 0, 0);
        step("R8", 16'h7000, 0, 1, 0, 0, 0, 0, 0);
        // random mix of accesses and window writes
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic cs;
            cs = ($urandom_range(0, 7) == 0);
            a  = $urandom_range(0, 16'hFFFF);
            if (cs && $urandom_range(0, 1) == 1) a[7:0] = OFS;
            step("R5", a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), cs,
                 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule